// File: doc/BRIEF.md
# Two-Channel Interrupt Vector Controller

This block sits between two peripheral channels and a shared system bus. Each channel presents an interrupt line and an interrupt enable line. When at least one channel has both lines high, the block raises a bus request on one configured priority level and waits for the arbiter's grant. On the grant it takes bus mastership, picks the channel to service, and drives a 9-bit interrupt vector on the data lines until the processor acknowledges.

The vector has three parts. The upper six bits come from a configuration input. Bit 2 tells the processor which channel is being serviced. The two lowest bits are always zero. With a base of octal 17, channel A therefore reads as octal 170 and channel B as octal 174. Channel B wins when both channels are pending. The choice and the base are captured at the grant. After the acknowledge the block releases the bus. A request whose cause disappears before the grant is withdrawn without being serviced.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While `bus_master` is high, `vec_data[8:3]` equals `vec_base` as it was sampled at the grant, and `vec_data[1:0]` is 0.
- R2: `vec_data[2]` is 0 when channel A is serviced and 1 when channel B is serviced.
- R3: A channel counts as pending only when its interrupt line and its enable line are both 1. Either line alone causes no request.
- R4: The request is driven only on `bus_br` bit index REQ_LVL-LOW_LVL, which is bit 0 (level four) by default. The other bits stay 0, and `bus_br` is zero while the block is master.
- R5: From idle, `bus_br` goes high in the cycle after a channel becomes pending. `bus_master` goes high in the cycle after `bus_grant` is seen while a channel is still pending.
- R6: When both channels are pending at the grant, channel B is serviced.
- R7: The serviced channel and the vector stay unchanged while `bus_master` is high, whatever the channel inputs or `vec_base` do.
- R8: `bus_master` and the vector hold until `bus_ack` is sampled high. In the next cycle `bus_master` is 0 and `vec_data` is 0.
- R9: If no channel is pending in the cycle a grant would be taken, the block takes no mastership and drops `bus_br` in the next cycle.
- R10: `vec_data` is 0 whenever `bus_master` is 0.
- R11: After reset `bus_br`, `bus_master` and `vec_data` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_a | input | 1 | Channel A interrupt line |
| ena_a | input | 1 | Channel A interrupt enable |
| irq_b | input | 1 | Channel B interrupt line |
| ena_b | input | 1 | Channel B interrupt enable |
| vec_base | input | 6 | Configured upper vector bits |
| bus_br | output | 4 | Bus request, one bit per priority level (levels 4 to 7) |
| bus_grant | input | 1 | Grant from the bus arbiter |
| bus_ack | input | 1 | Processor acknowledge of the vector |
| bus_master | output | 1 | Block holds the bus and drives the vector |
| vec_data | output | 9 | Interrupt vector data lines |

## Verification
The hardest case to reach is a pending request that vanishes in the same cycle the grant arrives. Close behind it is a channel whose inputs change while the vector is already on the bus. Random channel, grant and acknowledge activity hits the first only now and then. The bench therefore adds directed sequences that clear a channel's enable together with the grant, and that swap the pending channels and the base during mastership. A cycle-level reference model checks every cycle of the random traffic.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_REQ    = 2'd1,
      SEQ_MASTER = 2'd2
   } seq_state_e;

   localparam int NUM_CH = 2;
endpackage

// File: rtl/irq_vec_qual.sv
module irq_vec_qual #(
   parameter int SYNC_IN = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   input  logic ena,
   output logic pend
);
   logic raw;
   assign raw = irq & ena;

   generate
      if (SYNC_IN != 0) begin : g_reg
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= raw;
         end
         assign pend = pend_q;
      end else begin : g_comb
         assign pend = raw;
      end
   endgenerate
endmodule

// File: rtl/irq_vec_sel.sv
module irq_vec_sel (
   input  logic [irq_vec_pkg::NUM_CH-1:0] pend,
   output logic                           any,
   output logic                           win_b
);
   // channel index 1 (B) outranks index 0 (A)
   assign any   = |pend;
   assign win_b = pend[1];
endmodule

// File: rtl/irq_vec_seq.sv
module irq_vec_seq #(
   parameter int BASE_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              any,
   input  logic              win_b,
   input  logic              grant,
   input  logic              ack,
   input  logic [BASE_W-1:0] base,
   output logic              req,
   output logic              master,
   output logic              ch_q,
   output logic [BASE_W-1:0] base_q
);
   import irq_vec_pkg::*;

   seq_state_e st_q, st_d;
   logic       take;

   always_comb begin
      st_d = st_q;
      take = 1'b0;
      unique case (st_q)
         SEQ_IDLE:   if (any) st_d = SEQ_REQ;
         SEQ_REQ: begin
            if (!any) st_d = SEQ_IDLE;
            else if (grant) begin
               st_d = SEQ_MASTER;
               take = 1'b1;
            end
         end
         SEQ_MASTER: if (ack) st_d = SEQ_IDLE;
         default:    st_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SEQ_IDLE;
         ch_q   <= 1'b0;
         base_q <= '0;
      end else begin
         st_q <= st_d;
         if (take) begin
            ch_q   <= win_b;
            base_q <= base;
         end
      end
   end

   assign req    = (st_q == SEQ_REQ);
   assign master = (st_q == SEQ_MASTER);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int VEC_W   = 9,
   parameter int NUM_LVL = 4,
   parameter int LOW_LVL = 4,
   parameter int REQ_LVL = 4,
   parameter int SYNC_IN = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                irq_a,
   input  logic                ena_a,
   input  logic                irq_b,
   input  logic                ena_b,
   input  logic [VEC_W-4:0]    vec_base,
   output logic [NUM_LVL-1:0]  bus_br,
   input  logic                bus_grant,
   input  logic                bus_ack,
   output logic                bus_master,
   output logic [VEC_W-1:0]    vec_data
);
   import irq_vec_pkg::*;

   localparam int BASE_W  = VEC_W - 3;
   localparam int LVL_IDX = REQ_LVL - LOW_LVL;

   generate
      if (VEC_W < 4) begin : g_bad_w
         $error("VEC_W must leave at least one base bit");
      end
      if (REQ_LVL < LOW_LVL || REQ_LVL >= LOW_LVL + NUM_LVL) begin : g_bad_lvl
         $error("REQ_LVL outside the request lines");
      end
   endgenerate

   logic [NUM_CH-1:0] irq_v, ena_v, pend;
   assign irq_v = {irq_b, irq_a};
   assign ena_v = {ena_b, ena_a};

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         irq_vec_qual #(.SYNC_IN(SYNC_IN)) u_qual (
            .clk  (clk),
            .rst_n(rst_n),
            .irq  (irq_v[c]),
            .ena  (ena_v[c]),
            .pend (pend[c])
         );
      end
   endgenerate

   logic any, win_b, req, master, ch_q;
   logic [BASE_W-1:0] base_q;

   irq_vec_sel u_sel (
      .pend (pend),
      .any  (any),
      .win_b(win_b)
   );

   irq_vec_seq #(.BASE_W(BASE_W)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .any   (any),
      .win_b (win_b),
      .grant (bus_grant),
      .ack   (bus_ack),
      .base  (vec_base),
      .req   (req),
      .master(master),
      .ch_q  (ch_q),
      .base_q(base_q)
   );

   generate
      for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
         if (l == LVL_IDX) begin : g_on
            assign bus_br[l] = req;
         end else begin : g_off
            assign bus_br[l] = 1'b0;
         end
      end
   endgenerate

   assign bus_master = master;
   assign vec_data   = master ? {base_q, ch_q, 2'b00} : '0;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
   parameter int VEC_W   = 9,
   parameter int NUM_LVL = 4,
   parameter int LVL_IDX = 0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_LVL-1:0] bus_br,
   input logic               bus_grant,
   input logic               bus_ack,
   input logic               bus_master,
   input logic [VEC_W-1:0]   vec_data
);
   localparam logic [NUM_LVL-1:0] LVL_HOT = NUM_LVL'(1) << LVL_IDX;

   // R10
   a_r10_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_master |-> vec_data == '0);
   // R1
   a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      bus_master |-> vec_data[1:0] == 2'b00);
   // R7
   a_r7_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
      bus_master && $past(bus_master) |-> $stable(vec_data));
   // R8
   a_r8_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      bus_master && bus_ack |=> !bus_master);
   // R4
   a_r4_level_line: assert property (@(posedge clk) disable iff (!rst_n)
      (|bus_br) |-> bus_br == LVL_HOT);
   // R4
   a_r4_no_req_as_master: assert property (@(posedge clk) disable iff (!rst_n)
      bus_master |-> bus_br == '0);
   // R5
   a_r5_master_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_master) |-> $past(|bus_br) && $past(bus_grant));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_br    (bus_br),
   .bus_grant (bus_grant),
   .bus_ack   (bus_ack),
   .bus_master(bus_master),
   .vec_data  (vec_data)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
   localparam int CLK_P    = 10;
   localparam int N_RAND   = 3000;
   localparam int WD_LIMIT = 20000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       irq_a, ena_a, irq_b, ena_b;
   logic [5:0] vec_base;
   logic [3:0] bus_br;
   logic       bus_grant, bus_ack, bus_master;
   logic [8:0] vec_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc_n = 0;

   always #(CLK_P/2) clk = ~clk;

   irq_vec_ctrl i_irq_vec_ctrl (
      .clk(clk), .rst_n(rst_n),
      .irq_a(irq_a), .ena_a(ena_a), .irq_b(irq_b), .ena_b(ena_b),
      .vec_base(vec_base), .bus_br(bus_br), .bus_grant(bus_grant),
      .bus_ack(bus_ack), .bus_master(bus_master), .vec_data(vec_data)
   );

   // reference model: 0 idle, 1 requesting, 2 master
   int         m_st = 0;
   logic       m_ch = 1'b0;
   logic [5:0] m_base = '0;

   always @(posedge clk) begin
      cyc_n <= cyc_n + 1;
      if (!rst_n) begin
         m_st <= 0; m_ch <= 1'b0; m_base <= '0;
      end else begin
         case (m_st)
            0: if ((irq_a & ena_a) | (irq_b & ena_b)) m_st <= 1;
            1: if (!((irq_a & ena_a) | (irq_b & ena_b))) m_st <= 0;
               else if (bus_grant) begin
                  m_st <= 2; m_ch <= irq_b & ena_b; m_base <= vec_base;
               end
            default: if (bus_ack) m_st <= 0;
         endcase
      end
   end

   function automatic logic [8:0] exp_vec(int st, logic ch, logic [5:0] b);
      return (st == 2) ? {b, ch, 2'b00} : 9'd0;
   endfunction

   function automatic logic [3:0] exp_br(int st);
      return (st == 1) ? 4'b0001 : 4'b0000;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_cmp();
      chk("R4 R5 bus_br", 32'(bus_br), 32'(exp_br(m_st)));
      chk("R5 R8 R9 bus_master", 32'(bus_master), 32'(m_st == 2));
      chk((m_st == 2) ? "R1 R2 vec" : "R10 vec", 32'(vec_data),
          32'(exp_vec(m_st, m_ch, m_base)));
   endtask

   task automatic cyc();
      @(negedge clk);
      model_cmp();
   endtask

   task automatic drive(logic ia, logic ea, logic ib, logic eb, logic g, logic k);
      irq_a = ia; ena_a = ea; irq_b = ib; ena_b = eb; bus_grant = g; bus_ack = k;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(negedge clk) begin
      if (cyc_n > WD_LIMIT) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected<%0d", cyc_n, WD_LIMIT);
         finish_run();
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'h5EED_1C0D);
      rst_n = 1'b0; vec_base = 6'o17;
      drive(0, 0, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11 reset state
      chk("R11 bus_br", 32'(bus_br), 0);
      chk("R11 bus_master", 32'(bus_master), 0);
      chk("R11 vec_data", 32'(vec_data), 0);

      // R3 one line of each pair only
      drive(1, 0, 0, 1, 1, 0);
      repeat (3) cyc();
      chk("R3 no request", 32'(bus_br), 0);

      // R1 channel A alone -> octal 170
      drive(1, 1, 0, 0, 0, 0);
      cyc();
      chk("R5 request raised", 32'(bus_br), 1);
      bus_grant = 1;
      cyc();
      chk("R1 vector A", 32'(vec_data), 9'o170);
      bus_grant = 0; bus_ack = 1;
      cyc();
      chk("R8 released", 32'(bus_master), 0);
      drive(0, 0, 0, 0, 0, 0);
      cyc();

      // R6 both pending -> B, octal 174
      drive(1, 1, 1, 1, 0, 0);
      cyc();
      bus_grant = 1;
      cyc();
      chk("R6 B first", 32'(vec_data), 9'o174);
      // R7 change inputs and base during mastership
      drive(1, 1, 0, 0, 0, 0); vec_base = 6'o27;
      repeat (3) cyc();
      chk("R7 vector held", 32'(vec_data), 9'o174);
      chk("R8 held without ack", 32'(bus_master), 1);
      bus_ack = 1;
      cyc();
      chk("R8 drop after ack", 32'(bus_master), 0);
      chk("R8 vec cleared", 32'(vec_data), 0);
      drive(0, 0, 0, 0, 0, 0);
      cyc();

      // R9 request vanishes together with the grant
      drive(0, 0, 1, 1, 0, 0);
      cyc();
      chk("R9 request up", 32'(bus_br), 1);
      drive(0, 0, 1, 0, 1, 0);
      cyc();
      chk("R9 not serviced", 32'(bus_master), 0);
      chk("R9 request withdrawn", 32'(bus_br), 0);
      drive(0, 0, 0, 0, 0, 0);
      cyc();

      // random traffic against the model
      for (int i = 0; i < N_RAND; i++) begin
         irq_a     = ($urandom_range(3) != 0);
         ena_a     = ($urandom_range(3) != 0);
         irq_b     = ($urandom_range(2) == 0);
         ena_b     = ($urandom_range(3) != 0);
         bus_grant = ($urandom_range(4) < 2);
         bus_ack   = ($urandom_range(3) == 0);
         vec_base  = 6'($urandom);
         cyc();
      end
      finish_run();
   end
endmodule